// File: doc/BRIEF.md
# Four-Pin GPIO Register Bank with Input Inversion

This block is the register side of a small general-purpose I/O expander. A byte-wide register port, meant to be driven by a serial bus engine that sits outside this block, reaches four 8-bit registers. One is the input view, which is read-only. The other three are writable: the output values, the per-bit input polarity and the pin direction. The block drives a value and an enable for each of its four pins. It takes in the raw pin levels and passes them through a two-flop synchronizer.

A direction bit of 1 leaves its pin undriven, as an input. A 0 turns the driver on, with the level taken from the matching output bit. Reading the input register returns the synchronized pin levels, whatever the direction of each pin. Each level is XORed with its polarity bit. Reading any other register returns the stored byte, never the pin level. Read data is registered and appears the cycle after the read strobe.

Top module: `quad_gpio_bank`

## Requirements
- R1: After reset, direction reads 0xFF, output reads 0xFF and polarity reads 0x00, all four pin enables are 0, all pin outputs are 0, and rdata_o is 0x00.
- R2: The register at index 3 sets direction. Its bit i = 1 forces pin_oe_o[i] = 0 (input), and bit i = 0 sets pin_oe_o[i] = 1 (output), from the clock edge that samples the write.
- R3: pin_out_o[i] equals output-register bit i (index 1) while pin i is an output, and is 0 while it is an input. A change shows from the clock edge that samples the write.
- R4: A read of index 0 returns 0xF in bits 7..4, and the synchronized pin levels in bits 3..0, whether each pin is an input or an output.
- R5: Polarity register (index 2) bit i = 1 returns bit i of an index-0 read inverted; bit i = 0 returns it unchanged.
- R6: A write to index 0 changes no register, no pin output and no pin enable.
- R7: Reads of indices 1, 2 and 3 return all 8 bits exactly as last written, upper bits included. The output register returns its stored value, not the pin level.
- R8: A pin level that is set up before clock edge k is seen by a read strobe sampled at edge k+2 or later. A strobe at edge k+1 still sees the previous level.
- R9: rdata_o updates at the edge that samples rd_en_i, and holds its value while rd_en_i is low.
- R10: When a read and a write to the same index are sampled at the same edge, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle |
| rd_en_i | input | 1 | Read strobe, one cycle |
| idx_i | input | 2 | Register index: 0 input, 1 output, 2 polarity, 3 direction |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pin_in_i | input | 4 | Raw pin levels, asynchronous |
| pin_out_o | output | 4 | Pin drive values |
| pin_oe_o | output | 4 | Pin output enables |

## Verification
The block has two latencies. A write reaches the pin outputs and enables at the same edge that samples it, so they can be compared half a cycle later. A read result appears on rdata_o at the edge that samples the strobe. An index-0 read additionally sees a pin change only two edges after that change was sampled. The bench model keeps a two-entry queue of past pin samples and its own copies of the registers, and updates them at each rising edge. It then compares rdata_o, pin_out_o and pin_oe_o on every falling edge, so each result is checked in the cycle it is due, including reads issued right after a pin change.

// File: rtl/quad_gpio_pkg.sv
package quad_gpio_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_IN  = 2'd0,
    IDX_OUT = 2'd1,
    IDX_POL = 2'd2,
    IDX_DIR = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import quad_gpio_pkg::*;
#(
  parameter logic [REG_W-1:0] OUT_RST = 8'hFF,
  parameter logic [REG_W-1:0] POL_RST = 8'h00,
  parameter logic [REG_W-1:0] DIR_RST = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] out_q_o,
  output logic [REG_W-1:0] pol_q_o,
  output logic [REG_W-1:0] dir_q_o
);
  localparam int unsigned NREG = 3;
  localparam logic [REG_W-1:0] RST_VAL [NREG] = '{OUT_RST, POL_RST, DIR_RST};

  logic [REG_W-1:0] reg_q [NREG];

  // slot k serves index k+1; index 0 has no storage, so writes to it fall away
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reg_q[k] <= RST_VAL[k];
      else if (wr_en_i && (idx_i == IDX_W'(k + 1)))
        reg_q[k] <= wdata_i;
    end
  end

  assign out_q_o = reg_q[0];
  assign pol_q_o = reg_q[1];
  assign dir_q_o = reg_q[2];

  // R7: a write to a stored index is held exactly
  a_r7_write_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_DIR) |=> (dir_q_o == $past(wdata_i)));

  // R6: index 0 writes touch nothing
  a_r6_idx0_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_IN) |=> ($stable(out_q_o) && $stable(pol_q_o) && $stable(dir_q_o)));
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import quad_gpio_pkg::*;
#(
  parameter int unsigned NPIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NPIN-1:0]  pins_i,
  input  logic [REG_W-1:0] out_q_i,
  input  logic [REG_W-1:0] pol_q_i,
  input  logic [REG_W-1:0] dir_q_i,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] in_view;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    in_view = '1;  // unused input bits read as 1
    in_view[NPIN-1:0] = pins_i ^ pol_q_i[NPIN-1:0];
  end

  always_comb begin
    unique case (reg_idx_e'(idx_i))
      IDX_IN:  rd_mux = in_view;
      IDX_OUT: rd_mux = out_q_i;
      IDX_POL: rd_mux = pol_q_i;
      default: rd_mux = dir_q_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (rd_en_i)  rdata_o <= rd_mux;
  end

  // R9: read data holds between strobes
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R4: unused input bits read as ones
  a_r4_upper_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && idx_i == IDX_IN) |=> (rdata_o[REG_W-1:NPIN] == '1));

  // R7: stored registers read back their pre-edge value
  a_r7_out_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && idx_i == IDX_OUT) |=> (rdata_o == $past(out_q_i)));
endmodule

// File: rtl/quad_gpio_bank.sv
module quad_gpio_bank
  import quad_gpio_pkg::*;
#(
  parameter int unsigned NPIN        = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [NPIN-1:0]  pin_in_i,
  output logic [NPIN-1:0]  pin_out_o,
  output logic [NPIN-1:0]  pin_oe_o
);
  logic [REG_W-1:0] out_q, pol_q, dir_q;
  logic [NPIN-1:0]  pins_sync;

  gpio_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pins_sync)
  );

  gpio_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .idx_i   (idx_i),
    .wdata_i (wdata_i),
    .out_q_o (out_q),
    .pol_q_o (pol_q),
    .dir_q_o (dir_q)
  );

  gpio_read_port #(.NPIN(NPIN)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .idx_i   (idx_i),
    .pins_i  (pins_sync),
    .out_q_i (out_q),
    .pol_q_i (pol_q),
    .dir_q_i (dir_q),
    .rdata_o (rdata_o)
  );

  assign pin_oe_o  = ~dir_q[NPIN-1:0];
  assign pin_out_o = out_q[NPIN-1:0] & pin_oe_o;

  // R2: enables follow a direction write at the next edge
  a_r2_oe_after_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_DIR) |=> (pin_oe_o == ~$past(wdata_i[NPIN-1:0])));

  // R6: index 0 writes leave the pins alone
  a_r6_pins_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_IN) |=> ($stable(pin_out_o) && $stable(pin_oe_o)));

  // R3: an undriven pin carries no output value
  a_r3_input_pin_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_out_o & ~pin_oe_o) == '0));
endmodule

// File: tb/tb_quad_gpio_bank.sv
module tb_quad_gpio_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // reference state
  int m_out, m_pol, m_dir, m_rd;
  int pin_hist[$];

  always #10 clk = ~clk;

  quad_gpio_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .idx_i(idx), .wdata_i(wdata), .rdata_o(rdata),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 'hFF; m_pol = 0; m_dir = 'hFF; m_rd = 0;
      pin_hist = '{0, 0};
    end else begin
      if (rd_en) begin
        case (idx)
          2'd0: m_rd = 'hF0 | ((pin_hist[0] ^ m_pol) & 'hF);
          2'd1: m_rd = m_out;
          2'd2: m_rd = m_pol;
          default: m_rd = m_dir;
        endcase
      end
      if (wr_en) begin
        case (idx)
          2'd1: m_out = wdata;
          2'd2: m_pol = wdata;
          2'd3: m_dir = wdata;
          default: ;
        endcase
      end
      pin_hist.push_back(int'(pin_in));
      void'(pin_hist.pop_front());
    end
  end

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int oe;
    oe = (~m_dir) & 'hF;
    check("rdata", int'(rdata), m_rd);
    check("pin_oe", int'(pin_oe), oe);
    check("pin_out", int'(pin_out), m_out & oe);
  end

  task automatic op(bit w, bit r, logic [1:0] i, logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; idx = i; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic set_pins(logic [3:0] p);
    @(negedge clk);
    pin_in = p;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1"; idle(2);
    op(0, 1, 2'd1, 0); op(0, 1, 2'd2, 0); op(0, 1, 2'd3, 0);
    cur_req = "R9"; idle(3); op(0, 1, 2'd0, 0); idle(2);
    cur_req = "R7";
    op(1, 0, 2'd1, 8'hA5); op(1, 0, 2'd2, 8'h30); op(1, 0, 2'd3, 8'h5F);
    op(0, 1, 2'd1, 0); op(0, 1, 2'd2, 0); op(0, 1, 2'd3, 0);
    cur_req = "R2"; op(1, 0, 2'd3, 8'hF0); op(1, 0, 2'd3, 8'h06);
    cur_req = "R3";
    op(1, 0, 2'd1, 8'h0C); op(1, 0, 2'd3, 8'h00); op(1, 0, 2'd1, 8'h13);
    op(1, 0, 2'd3, 8'hF3); op(0, 1, 2'd1, 0);
    cur_req = "R4"; op(1, 0, 2'd3, 8'h00); op(1, 0, 2'd2, 8'h00);
    for (int p = 0; p < 16; p += 5) begin
      set_pins(4'(p)); idle(3); op(0, 1, 2'd0, 0);
    end
    cur_req = "R5";
    op(1, 0, 2'd2, 8'h06); op(0, 1, 2'd0, 0);
    op(1, 0, 2'd2, 8'hFF); set_pins(4'h3); idle(3); op(0, 1, 2'd0, 0);
    cur_req = "R8";
    op(1, 0, 2'd2, 8'h00); set_pins(4'hA); idle(3);
    set_pins(4'h5); op(0, 1, 2'd0, 0); op(0, 1, 2'd0, 0); op(0, 1, 2'd0, 0);
    cur_req = "R6";
    op(1, 0, 2'd0, 8'h00); op(1, 0, 2'd0, 8'hFF);
    op(0, 1, 2'd1, 0); op(0, 1, 2'd2, 0); op(0, 1, 2'd3, 0);
    cur_req = "R10";
    op(1, 1, 2'd1, 8'h7E); op(0, 1, 2'd1, 0);
    op(1, 1, 2'd3, 8'hC9); op(0, 1, 2'd3, 0);
    cur_req = "R9"; idle(4);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule